// File: doc/BRIEF.md
# Overcurrent Alarm Conditioner

This block takes a raw overcurrent alarm pin from outside the chip and turns it into two things for the rest of the device: a throttle request and an event-count interrupt. The pin first passes through a two-flop synchronizer. Its polarity can be set either way. Each time the corrected alarm goes from inactive to active, that counts as one event. An event counter totals these events. A single-cycle interrupt pulse is raised when the total reaches a programmed threshold, and the counter then starts again from zero. If a programmable number of clocks passes with no event, the counter clears and the quiet window starts again.

The throttle request follows the corrected alarm. After the alarm goes inactive, the request stays high for a programmable number of hold ticks, so a throttle arbiter downstream does not see a brief drop when the alarm chatters. Hold ticks are counted on a strobe input, so the hold time can be scaled to any time base. Every setting is a plain input held steady by the surrounding logic.

Top module: `oc_alarm_filter`

## Requirements
- R1: When `cfg_active_low` is 1, a low level on `alarm_pin` is the alarm. When it is 0, a high level is the alarm. Inverting both the pin and this setting gives identical outputs.
- R2: One event is counted for each inactive-to-active transition of the corrected alarm. An alarm held active for any length of time counts once.
- R3: With `cfg_thresh_en`=1 and `cfg_thresh`=T≥1, the T-th event since the count was last zero raises `irq_pulse` for exactly one clock. The count returns to 0 in the same cycle.
- R4: With `cfg_thresh_en`=1 and `cfg_thresh`=0, every event raises `irq_pulse`, and `event_count` stays 0.
- R5: With `cfg_thresh_en`=0, `irq_pulse` never rises. `event_count` counts events and saturates at 2^CNT_W-1.
- R6: With `cfg_quiet_clks`=L>0, `event_count` returns to 0 exactly L clocks after the clock in which it was last incremented, if no event occurs in between. A later event then counts from 1.
- R7: With `cfg_quiet_clks`=0, the count never clears because of quiet time.
- R8: `throttle_req` is high while the corrected alarm is active. It stays high for `cfg_hold_ticks` asserted `hold_tick` cycles after the alarm goes inactive. With a hold of 0, it drops together with the alarm.
- R9: During and after reset, `throttle_req`, `irq_pulse` and `event_count` are 0. A pin sitting at its inactive level when reset is released causes no event.
- R10: With the default synchronizer, a change on `alarm_pin` reaches `throttle_req` after 2 clock edges and reaches `event_count` after 3 clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alarm_pin | input | 1 | Raw asynchronous overcurrent alarm |
| cfg_active_low | input | 1 | 1: alarm is active low; 0: active high |
| cfg_thresh_en | input | 1 | Enables the count-threshold interrupt |
| cfg_thresh | input | CNT_W | Events per interrupt (0 = every event) |
| cfg_quiet_clks | input | QUIET_W | Quiet clocks before the count clears (0 = never) |
| cfg_hold_ticks | input | HOLD_W | Hold ticks after alarm release |
| hold_tick | input | 1 | Time-base strobe for the hold countdown |
| throttle_req | output | 1 | Stretched throttle request |
| irq_pulse | output | 1 | One-cycle threshold interrupt |
| event_count | output | CNT_W | Current event count |

## Verification
The hardest conditions to reach are the clock-exact expiry of the quiet window and the saturated count. Counter wrap cannot be seen without more than 2^CNT_W events, and the quiet clear is only observable if no further edge arrives for the whole window. The bench gets to the quiet clear with a single short pulse while threshold interrupts are off. It then counts, at every falling clock edge, how many samples show a non-zero count, and compares that number with L. It reaches saturation by sending a few more than 255 clean pulses with the interrupt disabled. The hold path is exercised with a strobe running at full rate and with one running at half rate.

// File: rtl/oc_filter_pkg.sv
package oc_filter_pkg;

   // What the event counter does in a given cycle
   typedef enum logic [1:0] {
      CNT_HOLD  = 2'd0,
      CNT_STEP  = 2'd1,
      CNT_FIRE  = 2'd2,
      CNT_QUIET = 2'd3
   } cnt_action_e;

   localparam int unsigned DEF_CNT_W   = 8;
   localparam int unsigned DEF_QUIET_W = 16;
   localparam int unsigned DEF_HOLD_W  = 12;

endpackage

// File: rtl/oc_pin_sync.sv
module oc_pin_sync #(
   parameter bit SYNC_BYPASS = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic active_low,
   output logic active,
   output logic rise
);

   // polarity folded in before the sync chain so reset value 0 is always "inactive"
   logic level_raw;
   logic act_q;

   assign level_raw = pin ^ active_low;

   generate
      if (SYNC_BYPASS) begin : g_bypass
         assign active = level_raw;
      end else begin : g_two_flop
         logic s1_q, s2_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               s1_q <= 1'b0;
               s2_q <= 1'b0;
            end else begin
               s1_q <= level_raw;
               s2_q <= s1_q;
            end
         end
         assign active = s2_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) act_q <= 1'b0;
      else        act_q <= active;
   end

   assign rise = active & ~act_q;

   // an edge can never repeat in the next cycle
   assert_edge_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);

endmodule

// File: rtl/oc_event_counter.sv
module oc_event_counter
   import oc_filter_pkg::*;
#(
   parameter int unsigned CNT_W   = DEF_CNT_W,
   parameter int unsigned QUIET_W = DEF_QUIET_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rise,
   input  logic               thresh_en,
   input  logic [CNT_W-1:0]   thresh,
   input  logic [QUIET_W-1:0] quiet_clks,
   output logic [CNT_W-1:0]   count,
   output logic               irq
);

   localparam logic [CNT_W-1:0]   CNT_MAX = {CNT_W{1'b1}};
   localparam logic [QUIET_W-1:0] Q_ONE   = QUIET_W'(1);

   logic [CNT_W-1:0]   count_q;
   logic [QUIET_W-1:0] quiet_q;
   logic               irq_q;
   logic [CNT_W:0]     next_ev;
   logic               fire;
   logic               quiet_done;
   cnt_action_e        act;

   assign next_ev    = {1'b0, count_q} + {{CNT_W{1'b0}}, 1'b1};
   assign fire       = rise & thresh_en & (next_ev >= {1'b0, thresh});
   assign quiet_done = (quiet_clks != '0) && (quiet_q >= (quiet_clks - Q_ONE));

   always_comb begin
      if (fire)            act = CNT_FIRE;
      else if (rise)       act = CNT_STEP;
      else if (quiet_done) act = CNT_QUIET;
      else                 act = CNT_HOLD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
         quiet_q <= '0;
         irq_q   <= 1'b0;
      end else begin
         irq_q <= fire;
         unique case (act)
            CNT_FIRE: begin
               count_q <= '0;
               quiet_q <= '0;
            end
            CNT_STEP: begin
               if (count_q != CNT_MAX) count_q <= next_ev[CNT_W-1:0];
               quiet_q <= '0;
            end
            CNT_QUIET: begin
               count_q <= '0;
               quiet_q <= '0;
            end
            default: begin
               if (quiet_clks != '0) quiet_q <= quiet_q + Q_ONE;
            end
         endcase
      end
   end

   assign count = count_q;
   assign irq   = irq_q;

   assert_irq_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |=> !irq_q);

   assert_irq_clears_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> (count_q == '0));

   assert_no_irq_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> $past(thresh_en));

   // count only moves up on an edge, otherwise it can only fall to zero
   assert_count_moves_on_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (count_q != $past(count_q)) |-> ($past(rise) || (count_q == '0)));

endmodule

// File: rtl/oc_hold_stretch.sv
module oc_hold_stretch #(
   parameter int unsigned HOLD_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              tick,
   input  logic [HOLD_W-1:0] hold_ticks,
   output logic              req
);

   logic [HOLD_W-1:0] hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      hold_q <= '0;
      else if (active)                 hold_q <= hold_ticks;
      else if (tick && hold_q != '0)   hold_q <= hold_q - HOLD_W'(1);
   end

   assign req = active | (hold_q != '0);

   // once released, the remaining hold can only shrink
   assert_hold_no_grow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && $past(!active)) |-> (hold_q <= $past(hold_q)));

endmodule

// File: rtl/oc_alarm_filter.sv
module oc_alarm_filter
   import oc_filter_pkg::*;
#(
   parameter int unsigned CNT_W       = DEF_CNT_W,
   parameter int unsigned QUIET_W     = DEF_QUIET_W,
   parameter int unsigned HOLD_W      = DEF_HOLD_W,
   parameter bit          SYNC_BYPASS = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               alarm_pin,
   input  logic               cfg_active_low,
   input  logic               cfg_thresh_en,
   input  logic [CNT_W-1:0]   cfg_thresh,
   input  logic [QUIET_W-1:0] cfg_quiet_clks,
   input  logic [HOLD_W-1:0]  cfg_hold_ticks,
   input  logic               hold_tick,
   output logic               throttle_req,
   output logic               irq_pulse,
   output logic [CNT_W-1:0]   event_count
);

   generate
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
         $error("CNT_W out of range");
      end
      if (QUIET_W < 1 || QUIET_W > 32) begin : g_bad_quiet
         $error("QUIET_W out of range");
      end
      if (HOLD_W < 1 || HOLD_W > 32) begin : g_bad_hold
         $error("HOLD_W out of range");
      end
   endgenerate

   logic alarm_act;
   logic alarm_rise;

   oc_pin_sync #(.SYNC_BYPASS(SYNC_BYPASS)) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin        (alarm_pin),
      .active_low (cfg_active_low),
      .active     (alarm_act),
      .rise       (alarm_rise)
   );

   oc_event_counter #(.CNT_W(CNT_W), .QUIET_W(QUIET_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .rise       (alarm_rise),
      .thresh_en  (cfg_thresh_en),
      .thresh     (cfg_thresh),
      .quiet_clks (cfg_quiet_clks),
      .count      (event_count),
      .irq        (irq_pulse)
   );

   oc_hold_stretch #(.HOLD_W(HOLD_W)) u_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .active     (alarm_act),
      .tick       (hold_tick),
      .hold_ticks (cfg_hold_ticks),
      .req        (throttle_req)
   );

   assert_reset_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!irq_pulse && event_count == '0));

endmodule

// File: tb/oc_alarm_filter_test.sv
module oc_alarm_filter_test;

   localparam int CW = 8;
   localparam int QW = 16;
   localparam int HW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          alarm_pin = 1'b0;
   logic          cfg_active_low = 1'b0;
   logic          cfg_thresh_en = 1'b0;
   logic [CW-1:0] cfg_thresh = '0;
   logic [QW-1:0] cfg_quiet_clks = '0;
   logic [HW-1:0] cfg_hold_ticks = '0;
   logic          hold_tick = 1'b1;
   logic          throttle_req;
   logic          irq_pulse;
   logic [CW-1:0] event_count;

   int checks = 0;
   int errors = 0;
   int irq_total = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   oc_alarm_filter uut (
      .clk(clk), .rst_n(rst_n), .alarm_pin(alarm_pin),
      .cfg_active_low(cfg_active_low), .cfg_thresh_en(cfg_thresh_en),
      .cfg_thresh(cfg_thresh), .cfg_quiet_clks(cfg_quiet_clks),
      .cfg_hold_ticks(cfg_hold_ticks), .hold_tick(hold_tick),
      .throttle_req(throttle_req), .irq_pulse(irq_pulse),
      .event_count(event_count)
   );

   always @(negedge clk) if (irq_pulse) irq_total++;

   typedef struct packed {
      logic          al;
      logic          en;
      logic [7:0]    th;
      logic [15:0]   quiet;
      logic [15:0]   pulses;
      logic [15:0]   exp_irq;
      logic [7:0]    exp_cnt;
   } vec_t;

   localparam vec_t VECS [8] = '{
      '{1'b0, 1'b1, 8'd3, 16'd0,  16'd7, 16'd2, 8'd1},   // R3 high-active
      '{1'b1, 1'b1, 8'd3, 16'd0,  16'd7, 16'd2, 8'd1},   // R1 same, low-active
      '{1'b0, 1'b1, 8'd0, 16'd0,  16'd5, 16'd5, 8'd0},   // R4
      '{1'b0, 1'b0, 8'd2, 16'd0,  16'd5, 16'd0, 8'd5},   // R5
      '{1'b1, 1'b1, 8'd1, 16'd0,  16'd4, 16'd4, 8'd0},   // R3 T=1
      '{1'b0, 1'b1, 8'd4, 16'd50, 16'd4, 16'd1, 8'd0},   // R3 with window on
      '{1'b1, 1'b1, 8'd5, 16'd50, 16'd3, 16'd0, 8'd3},   // R6 window not yet expired
      '{1'b0, 1'b0, 8'd9, 16'd0,  16'd9, 16'd0, 8'd9}    // R5 / R7
   };

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic check_range(input string req, input int act, input int lo, input int hi);
      checks++;
      if (act < lo || act > hi) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d..%0d", req, act, lo, hi);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      alarm_pin = cfg_active_low;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic pulse(input int width);
      alarm_pin = ~cfg_active_low;
      repeat (width) @(negedge clk);
      alarm_pin = cfg_active_low;
      repeat (2) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : main
      int base;
      int nz;
      int hi;

      // R9: state in and after reset, pin idle at inactive level (low-active)
      cfg_active_low = 1'b1;
      alarm_pin = 1'b1;
      repeat (2) @(negedge clk);
      check("R9 req in reset", throttle_req, 0);
      check("R9 irq in reset", irq_pulse, 0);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);
      check("R9 no spurious event", event_count, 0);
      check("R9 no spurious req", throttle_req, 0);

      // vector table
      for (int v = 0; v < 8; v++) begin
         cfg_active_low = VECS[v].al;
         cfg_thresh_en  = VECS[v].en;
         cfg_thresh     = VECS[v].th;
         cfg_quiet_clks = VECS[v].quiet;
         cfg_hold_ticks = '0;
         do_reset();
         base = irq_total;
         for (int p = 0; p < int'(VECS[v].pulses); p++) pulse(2);
         repeat (6) @(negedge clk);
         check($sformatf("R3/R4/R5 vec%0d irq count", v), irq_total - base, int'(VECS[v].exp_irq));
         check($sformatf("R1/R2 vec%0d event_count", v), event_count, int'(VECS[v].exp_cnt));
      end

      // R10 latency and R2 held alarm counts once
      cfg_active_low = 1'b0; cfg_thresh_en = 1'b0; cfg_quiet_clks = '0; cfg_hold_ticks = '0;
      do_reset();
      alarm_pin = 1'b1;
      @(negedge clk);
      check("R10 req after 1 edge", throttle_req, 0);
      @(negedge clk);
      check("R10 req after 2 edges", throttle_req, 1);
      check("R10 count after 2 edges", event_count, 0);
      @(negedge clk);
      check("R10 count after 3 edges", event_count, 1);
      repeat (40) @(negedge clk);
      check("R2 held alarm once", event_count, 1);
      check("R8 req while active", throttle_req, 1);
      alarm_pin = 1'b0;
      repeat (3) @(negedge clk);
      check("R8 zero hold drops", throttle_req, 0);

      // R6 quiet window: exact number of non-zero samples, then rearm
      cfg_quiet_clks = 16'd10;
      do_reset();
      nz = 0;
      alarm_pin = 1'b1;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (event_count != 0) nz++;
         if (i == 1) alarm_pin = 1'b0;
      end
      check("R6 count lifetime", nz, 10);
      pulse(2);
      @(negedge clk);
      check("R6 rearm counts from 1", event_count, 1);

      // R7 no clearing when window length is 0
      cfg_quiet_clks = '0;
      do_reset();
      pulse(2);
      repeat (300) @(negedge clk);
      check("R7 count kept", event_count, 1);

      // R5 saturation
      do_reset();
      for (int p = 0; p < 260; p++) pulse(2);
      repeat (4) @(negedge clk);
      check("R5 saturates", event_count, 255);

      // R8 hold with full-rate tick: W + H samples high
      cfg_hold_ticks = 12'd5;
      hold_tick = 1'b1;
      do_reset();
      hi = 0;
      alarm_pin = 1'b1;
      for (int i = 0; i < 30; i++) begin
         if (i == 3) alarm_pin = 1'b0;
         @(negedge clk);
         if (throttle_req) hi++;
      end
      check("R8 hold full-rate tick", hi, 8);

      // R8 hold with half-rate tick, low-active pin
      cfg_active_low = 1'b1;
      do_reset();
      hi = 0;
      alarm_pin = 1'b0;
      for (int i = 0; i < 40; i++) begin
         if (i == 3) alarm_pin = 1'b1;
         @(negedge clk);
         hold_tick = ~hold_tick;
         if (throttle_req) hi++;
      end
      check_range("R1/R8 hold half-rate tick", hi, 3 + 9, 3 + 11);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule